// File: doc/BRIEF.md
# Microsecond Interval Timer Set with Acknowledge-on-Read

The block holds one shared system timer and one timer for each of up to four processors. Every timer counts strobes of an external one-microsecond tick. It compares its count with a programmed limit. When the count reaches the limit it starts again from 1 and raises an interrupt. The shared timer drives the level-10 system interrupt line. Each processor timer drives its own level-14 line.

Software reaches the block through a word-addressed register port. Count and limit values sit in bits 30:10 of the register word. To get a period of P ticks, software writes (P+1) shifted left by 10. Reading a timer's primary limit word acknowledges that timer's interrupt. A second, shadow address for the same limit gives read and write access without the acknowledge. Each processor timer also has a run/hold control. The shared timer instead sits next to a configuration word.

Each timer runs a small state machine with three states. TS_FREE runs with a limit of zero and never matches. TS_MATCH runs and wraps on the limit. TS_HOLD is for processor timers only and freezes the count. The next state comes from the effective run bit and from whether the effective limit is zero. The following events re-evaluate it: a run write that takes the timer from TS_FREE or TS_MATCH to TS_HOLD or back; a limit write that moves it between TS_FREE and TS_MATCH; and a limit write made while the timer is held, which stays in TS_HOLD. The reset state is TS_FREE.

Top module: `ctr_timer_set`

## Requirements
- R1: After reset:
  - every count reads 1 and every limit reads 0;
  - every run bit reads 1 and the configuration word reads 0;
  - all interrupt outputs are low.
- R2: Limit and count words carry their value in bits 30:10. Bits 9:0 and bit 31 read as zero, and written values in those bits are dropped.
- R3: A running timer's count goes up by exactly one for each cycle in which `tick_us` is high. It does not change on cycles without a tick. The count word reads the live value.
- R4: The timer has a nonzero limit L. When a tick arrives with the count equal to L-1, the count becomes 1 and the timer's interrupt is set. This gives one interrupt every L-1 ticks.
- R5: A read of the primary limit word clears that timer's interrupt. If a wrap happens in the same cycle, the interrupt stays set.
- R6: A read of the shadow limit word returns the limit and leaves the interrupt unchanged. A write through either limit word loads the limit and sets the count to 1.
- R7: With a limit of zero the timer keeps counting and never raises its interrupt.
- R8: Bit 0 of a processor timer's run word controls the timer: 0 holds the count and 1 lets it run. The bit reads back in bit 0, with the other bits zero.
- R9: The shared timer drives `irq_lvl10`, and processor timer i drives `irq_lvl14[i]`. An event on one timer never changes another timer's interrupt.
- R10: Writes to a count word or to the reserved shared word are ignored, and the reserved word reads 0. The configuration word keeps the low NUM_CPU written bits and reads zero above them.
- R11: A read request returns its data on `rd_data` with `rd_valid` high one cycle later. When a limit write and a tick fall in the same cycle, the write takes effect and the count becomes 1.

Address map (word addresses):
- Processor timer i: 4i+0 primary limit, 4i+1 count, 4i+2 shadow limit, 4i+3 run.
- Shared timer (base 4·NUM_CPU): +0 primary limit, +1 count, +2 shadow limit, +3 reserved, +4 configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-cycle strobe, once per microsecond |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |
| irq_lvl10 | output | 1 | Shared timer interrupt |
| irq_lvl14 | output | NUM_CPU | Per-processor timer interrupts |

## Verification
The bench sweeps every timer through limits 2 to 7 and counts the exact tick on which the interrupt rises. A design that is off by one in the compare would raise it one tick early or late. It then checks that the shadow read leaves the interrupt pending and that the primary read clears it. A design that mixed up the two addresses would lose or keep an interrupt at the wrong moment. The bench also drives the following coincidences in the same cycle:
- an acknowledge together with a wrap, where a design that lets the clear win would drop an interrupt;
- a limit write together with a tick, where the count must restart at 1.

Held processor timers, zero limits, ignored writes and the masking of the reserved bits are each checked at the register port.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
    typedef enum logic [1:0] {
        TS_HOLD  = 2'd0,
        TS_FREE  = 2'd1,
        TS_MATCH = 2'd2
    } tmr_state_e;

    localparam logic [2:0] OFF_LIMIT = 3'd0;
    localparam logic [2:0] OFF_COUNT = 3'd1;
    localparam logic [2:0] OFF_ALIAS = 3'd2;
    localparam logic [2:0] OFF_AUX   = 3'd3;
    localparam logic [2:0] OFF_CFG   = 3'd4;
endpackage

// File: rtl/ctr_addr_dec.sv
module ctr_addr_dec #(
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = 5,
    parameter int IDX_W   = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic [2:0]        off,
    output logic              hit
);
    localparam int GLB_BASE = NUM_CPU * 4;
    localparam int GLB_LAST = GLB_BASE + 4;

    always_comb begin
        if (int'(addr) >= GLB_BASE) begin
            idx = IDX_W'(NUM_CPU);
            off = 3'(int'(addr) - GLB_BASE);
            hit = (int'(addr) <= GLB_LAST);
        end else begin
            idx = IDX_W'(addr >> 2);
            off = {1'b0, addr[1:0]};
            hit = 1'b1;
        end
    end
endmodule

// File: rtl/ctr_tmr.sv
module ctr_tmr
    import ctr_pkg::*;
#(
    parameter int VAL_W   = 21,
    parameter bit HAS_RUN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             lim_wr,
    input  logic [VAL_W-1:0] lim_val,
    input  logic             run_wr,
    input  logic             run_val,
    input  logic             rd_clr,
    output logic [VAL_W-1:0] limit_o,
    output logic [VAL_W-1:0] count_o,
    output logic             run_o,
    output logic             irq_o
);
    localparam logic [VAL_W-1:0] ONE = VAL_W'(1);

    tmr_state_e       st_q, st_d;
    logic [VAL_W-1:0] lim_q, cnt_q, lim_eff;
    logic             flag_q, run_eff, adv, match_en, wrap;

    // next-state decision
    always_comb begin
        lim_eff = lim_wr ? lim_val : lim_q;
        run_eff = HAS_RUN ? (run_wr ? run_val : (st_q != TS_HOLD)) : 1'b1;
        if (!run_eff)
            st_d = TS_HOLD;
        else if (lim_eff == '0)
            st_d = TS_FREE;
        else
            st_d = TS_MATCH;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TS_FREE;
        else        st_q <= st_d;
    end

    // per-state outputs
    always_comb begin
        unique case (st_q)
            TS_HOLD:  begin adv = 1'b0; match_en = 1'b0; end
            TS_FREE:  begin adv = tick; match_en = 1'b0; end
            TS_MATCH: begin adv = tick; match_en = 1'b1; end
            default:  begin adv = 1'b0; match_en = 1'b0; end
        endcase
        wrap = adv && match_en && (cnt_q == (lim_q - ONE)) && !lim_wr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q  <= '0;
            cnt_q  <= ONE;
            flag_q <= 1'b0;
        end else begin
            if (lim_wr) begin
                lim_q <= lim_val;
                cnt_q <= ONE;
            end else if (wrap) begin
                cnt_q <= ONE;
            end else if (adv) begin
                cnt_q <= cnt_q + ONE;
            end
            if (wrap)        flag_q <= 1'b1;
            else if (rd_clr) flag_q <= 1'b0;
        end
    end

    assign limit_o = lim_q;
    assign count_o = cnt_q;
    assign run_o   = (st_q != TS_HOLD);
    assign irq_o   = flag_q;
endmodule

// File: rtl/ctr_timer_set.sv
module ctr_timer_set
    import ctr_pkg::*;
#(
    parameter  int NUM_CPU = 4,
    parameter  int VAL_LSB = 10,
    parameter  int VAL_W   = 21,
    parameter  int DATA_W  = 32,
    localparam int ADDR_W  = $clog2(NUM_CPU * 4 + 5)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_us,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rd_valid,
    output logic [DATA_W-1:0]  rd_data,
    output logic               irq_lvl10,
    output logic [NUM_CPU-1:0] irq_lvl14
);
    localparam int NUM_T = NUM_CPU + 1;
    localparam int IDX_W = $clog2(NUM_T);
    localparam int GLB   = NUM_CPU;

    logic [IDX_W-1:0]  idx;
    logic [2:0]        off;
    logic              hit, is_rd, is_wr, cfg_wr;
    logic [VAL_W-1:0]  lim_a [NUM_T];
    logic [VAL_W-1:0]  cnt_a [NUM_T];
    logic [NUM_T-1:0]  run_a, irq_a, lim_wr, rd_clr, run_wr;
    logic [NUM_CPU-1:0] cfg_q;
    logic [DATA_W-1:0] rd_word;
    logic              unused_wbits;

    assign unused_wbits = ^{req_wdata[DATA_W-1], req_wdata[VAL_LSB-1:NUM_CPU]};

    ctr_addr_dec #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
        .addr(req_addr),
        .idx (idx),
        .off (off),
        .hit (hit)
    );

    assign is_rd  = req_valid && !req_write;
    assign is_wr  = req_valid && req_write && hit;
    assign cfg_wr = is_wr && (idx == IDX_W'(GLB)) && (off == OFF_CFG);

    for (genvar t = 0; t < NUM_T; t++) begin : g_tmr
        logic sel;
        assign sel       = (idx == IDX_W'(t)) && hit;
        assign lim_wr[t] = is_wr && sel && ((off == OFF_LIMIT) || (off == OFF_ALIAS));
        assign rd_clr[t] = is_rd && sel && (off == OFF_LIMIT);
        if (t < NUM_CPU) begin : g_cpu
            assign run_wr[t] = is_wr && sel && (off == OFF_AUX);
        end else begin : g_glb
            assign run_wr[t] = 1'b0;
        end

        ctr_tmr #(.VAL_W(VAL_W), .HAS_RUN(t < NUM_CPU)) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick_us),
            .lim_wr (lim_wr[t]),
            .lim_val(req_wdata[VAL_LSB +: VAL_W]),
            .run_wr (run_wr[t]),
            .run_val(req_wdata[0]),
            .rd_clr (rd_clr[t]),
            .limit_o(lim_a[t]),
            .count_o(cnt_a[t]),
            .run_o  (run_a[t]),
            .irq_o  (irq_a[t])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_wr) cfg_q <= req_wdata[NUM_CPU-1:0];
    end

    always_comb begin
        rd_word = '0;
        if (hit) begin
            case (off)
                OFF_LIMIT, OFF_ALIAS: rd_word[VAL_LSB +: VAL_W] = lim_a[idx];
                OFF_COUNT:            rd_word[VAL_LSB +: VAL_W] = cnt_a[idx];
                OFF_AUX:              if (idx != IDX_W'(GLB)) rd_word[0] = run_a[idx];
                OFF_CFG:              rd_word[NUM_CPU-1:0] = cfg_q;
                default:              rd_word = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= is_rd;
            if (is_rd) rd_data <= rd_word;
        end
    end

    assign irq_lvl10 = irq_a[GLB];
    assign irq_lvl14 = irq_a[NUM_CPU-1:0];
endmodule

// File: rtl/ctr_timer_set_chk.sv
module ctr_timer_set_chk #(
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick_us,
    input logic               req_valid,
    input logic               req_write,
    input logic [ADDR_W-1:0]  req_addr,
    input logic               rd_valid,
    input logic [DATA_W-1:0]  rd_data,
    input logic               irq_lvl10,
    input logic [NUM_CPU-1:0] irq_lvl14
);
    localparam logic [ADDR_W-1:0] GLB_LIM = ADDR_W'(NUM_CPU * 4);

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid); // R11
    AST_RD_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid); // R11
    AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !rd_data[DATA_W-1]); // R2
    AST_GLB_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lvl10 && !(req_valid && !req_write && req_addr == GLB_LIM)) |=> irq_lvl10); // R5
    AST_GLB_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_lvl10 && !tick_us) |=> !irq_lvl10); // R4
    AST_CPU_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_us |=> ($countones(irq_lvl14 & ~$past(irq_lvl14)) == 0)); // R4
endmodule

bind ctr_timer_set ctr_timer_set_chk #(
    .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_us  (tick_us),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .irq_lvl10(irq_lvl10),
    .irq_lvl14(irq_lvl14)
);

// File: tb/ctr_timer_set_tb.sv
`timescale 1ns/1ps
module ctr_timer_set_tb;
    localparam int NCPU = 4;
    localparam int AW   = 5;
    localparam int GB   = NCPU * 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            tick_us = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic [31:0]     req_wdata = '0;
    logic            rd_valid;
    logic [31:0]     rd_data;
    logic            irq_lvl10;
    logic [NCPU-1:0] irq_lvl14;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    ctr_timer_set u_dut (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .irq_lvl10(irq_lvl10), .irq_lvl14(irq_lvl14)
    );

    function automatic logic [31:0] lw(input int v);
        return 32'(v) << 10;
    endfunction

    function automatic logic irq_of(input int t);
        return (t < NCPU) ? irq_lvl14[t] : irq_lvl10;
    endfunction

    function automatic logic [AW-1:0] ad(input int t, input int k);
        return AW'(t * 4 + k);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus(input logic w, input logic [AW-1:0] a, input logic [31:0] d,
                       input logic tk, output logic [31:0] q);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; tick_us = tk;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; tick_us = 1'b0;
        q = rd_data;
        if (!w) check("R11 rd_valid", {31'b0, rd_valid}, 32'd1);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        logic [31:0] q;
        bus(1'b1, a, d, 1'b0, q);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] q);
        bus(1'b0, a, 32'd0, 1'b0, q);
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) begin
            tick_us = 1'b1;
            @(negedge clk);
            tick_us = 1'b0;
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] q;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq14", {28'b0, irq_lvl14}, 32'd0);
        check("R1 irq10", {31'b0, irq_lvl10}, 32'd0);
        for (int t = 0; t <= NCPU; t++) begin
            rd(ad(t, 1), q); check("R1 count", q, lw(1));
            rd(ad(t, 0), q); check("R1 limit", q, 32'd0);
            if (t < NCPU) begin rd(ad(t, 3), q); check("R1 run", q, 32'd1); end
        end
        rd(AW'(GB + 4), q); check("R1 config", q, 32'd0);

        // R7 R3 free running with zero limit
        tk(5);
        rd(ad(0, 1), q);    check("R3 count cpu0", q, lw(6));
        rd(ad(NCPU, 1), q); check("R3 count glb", q, lw(6));
        repeat (3) @(negedge clk);
        rd(ad(0, 1), q);    check("R3 no tick no change", q, lw(6));
        check("R7 no irq", {27'b0, irq_lvl10, irq_lvl14}, 32'd0);

        // R4 R5 R6 R9 sweep of each timer and limit
        for (int t = 0; t <= NCPU; t++) begin
            for (int lim = 2; lim <= 7; lim++) begin
                for (int o = 0; o <= NCPU; o++) wr(ad(o, 0), 32'd0);
                wr(ad(t, (lim % 2 == 0) ? 0 : 2), lw(lim));
                rd(ad(t, 1), q); check("R6 write reloads count", q, lw(1));
                tk(lim - 2);
                rd(ad(t, 1), q); check("R4 count before wrap", q, lw(lim - 1));
                check("R4 irq not early", {31'b0, irq_of(t)}, 32'd0);
                tk(1);
                check("R4 irq on wrap", {31'b0, irq_of(t)}, 32'd1);
                for (int o = 0; o <= NCPU; o++)
                    if (o != t) check("R9 other irq quiet", {31'b0, irq_of(o)}, 32'd0);
                rd(ad(t, 1), q); check("R4 count after wrap", q, lw(1));
                rd(ad(t, 2), q); check("R6 alias value", q, lw(lim));
                check("R6 alias keeps irq", {31'b0, irq_of(t)}, 32'd1);
                rd(ad(t, 0), q); check("R5 primary value", q, lw(lim));
                check("R5 read clears irq", {31'b0, irq_of(t)}, 32'd0);
            end
        end
        for (int o = 0; o <= NCPU; o++) wr(ad(o, 0), 32'd0);

        // R4 periodic repeat on the shared timer
        wr(ad(NCPU, 0), lw(4));
        tk(3); check("R4 first period", {31'b0, irq_lvl10}, 32'd1);
        rd(ad(NCPU, 0), q);
        tk(2); check("R4 second period early", {31'b0, irq_lvl10}, 32'd0);
        tk(1); check("R4 second period", {31'b0, irq_lvl10}, 32'd1);
        rd(ad(NCPU, 0), q);

        // R5 acknowledge coincident with a wrap
        wr(ad(NCPU, 0), lw(3));
        tk(2); check("R5 setup irq", {31'b0, irq_lvl10}, 32'd1);
        tk(1);
        bus(1'b0, ad(NCPU, 0), 32'd0, 1'b1, q);
        check("R5 wrap wins over clear", {31'b0, irq_lvl10}, 32'd1);
        rd(ad(NCPU, 0), q);
        check("R5 later clear", {31'b0, irq_lvl10}, 32'd0);
        wr(ad(NCPU, 0), 32'd0);

        // R11 limit write coincident with tick
        wr(ad(2, 0), lw(5));
        tk(2);
        rd(ad(2, 1), q); check("R11 setup count", q, lw(3));
        bus(1'b1, ad(2, 0), lw(5), 1'b1, q);
        rd(ad(2, 1), q); check("R11 write beats tick", q, lw(1));
        wr(ad(2, 0), 32'd0);

        // R8 hold and resume
        wr(ad(1, 0), 32'd0);
        wr(ad(1, 3), 32'hFFFF_FFFE);
        rd(ad(1, 3), q); check("R8 run reads 0", q, 32'd0);
        tk(4);
        rd(ad(1, 1), q); check("R8 held count", q, lw(1));
        wr(ad(1, 3), 32'd1);
        rd(ad(1, 3), q); check("R8 run reads 1", q, 32'd1);
        tk(2);
        rd(ad(1, 1), q); check("R8 resumed count", q, lw(3));

        // R10 ignored writes and config width
        wr(ad(0, 0), 32'd0);
        wr(ad(0, 1), lw(100));
        rd(ad(0, 1), q); check("R10 count write ignored", q, lw(1));
        wr(AW'(GB + 3), 32'hFFFF_FFFF);
        rd(AW'(GB + 3), q); check("R10 reserved zero", q, 32'd0);
        wr(AW'(GB + 4), 32'hFFFF_FFFF);
        rd(AW'(GB + 4), q); check("R10 config width", q, 32'h0000_000F);

        // R2 field masking
        wr(ad(3, 2), 32'hFFFF_FFFF);
        rd(ad(3, 0), q); check("R2 field mask", q, 32'h7FFF_FC00);
        rd(ad(3, 1), q); check("R2 count field", q, lw(1));

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule